// File: doc/BRIEF.md
# Buffer Single-Bit ECC Repair Engine

This engine sits beside the page buffer of a flash controller. After a page transfer has filled the buffer and an external ECC checker has produced a 4-bit result code, the engine is started once. It decides whether the data region, the out-of-band (spare) region, or both hold a single flipped bit. For each such region it performs one read-modify-write on the 16-bit buffer RAM, inverting exactly the reported bit. The checker reports a half-word index and a bit number for each region. The target half-word is found by adding that index to a region base plus a per-buffer offset.

Two-bit errors cannot be repaired. They raise an uncorrectable flag and the buffer is left unchanged. A history mode can be selected at start. In that mode a region is repaired only when the previous accepted operation also reported a single-bit error in the same region. This lets the engine cover pages that a front-end corrector handles on its own. The engine owns the RAM port only while busy. It returns a one-cycle done pulse when it has finished.

Top module: `bufecc_fixup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, done_o, uncorr_o, ram_rd_o and ram_wr_o are all low.
- R2: The result code carries the data-region result in bits [3:2] and the spare-region result in bits [1:0]. A field of 01 means one correctable bit and 10 means two bits. A field of 00 or 11 causes no RAM access and no uncorrectable flag.
- R3: A location word holds the half-word index above bit 4 and the bit number in bits [3:0]. A repair writes back the read half-word XOR a mask with only that bit set, so exactly one bit changes.
- R4: The data-region target is MAIN_BASE + index + MAIN_STRIDE*buffer, with defaults 0 and 256. The spare-region target is SPARE_BASE + index + SPARE_STRIDE*buffer, with defaults 1024 and 8. The buffer number is 0 to 3.
- R5: A start is accepted only when the engine is idle. Each repair uses one read cycle followed by one write cycle. The data region is handled before the spare region. The first read happens in the cycle after acceptance. done_o pulses for one cycle after the last write, or in the cycle after acceptance when there is nothing to repair. busy_o then falls.
- R6: If either field is 10, uncorr_o is high and no RAM read or write takes place for that operation.
- R7: When spare-only is set at start, the data region is never repaired. The spare region is still handled.
- R8: The result code, both location words, the buffer number, spare-only and the mode are taken at acceptance. Later changes to them do not alter the operation.
- R9: A start raised while busy is ignored. It changes neither the operation in progress, nor uncorr_o, nor the remembered history.
- R10: Each accepted start records, per region, whether that region reported exactly 01. Any other value clears the record. With history mode set, a region with 01 is repaired only if its record from the previous accepted start is set.
- R11: uncorr_o is updated in the cycle after acceptance and holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| buf_sel_i | input | 2 | Buffer number 0..3 |
| spare_only_i | input | 1 | Transfer covered the spare region only |
| hist_mode_i | input | 1 | Repair only on repeated single-bit results |
| status_i | input | 4 | ECC result code |
| main_loc_i | input | 12 | Data-region error location |
| spare_loc_i | input | 7 | Spare-region error location |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| uncorr_o | output | 1 | Last accepted operation saw a two-bit error |
| ram_rd_o | output | 1 | Buffer RAM read strobe |
| ram_wr_o | output | 1 | Buffer RAM write strobe |
| ram_addr_o | output | 11 | Buffer RAM half-word address |
| ram_wdata_o | output | 16 | Buffer RAM write data |
| ram_rdata_i | input | 16 | Buffer RAM read data, one cycle after the read strobe |

## Verification
The hardest behaviour to reach from the ports is history mode. A repair there depends on what the previous accepted operation reported, so a single stimulus cannot exercise it. The stimulus therefore chains operations: a clean one, then single errors in one region, then the other region, then a two-bit error that clears one record while setting the other. The reference model carries the per-region records across all operations. A start pulse is also raised in the middle of operations with different inputs, and every input is inverted right after acceptance. Together these show that nothing outside the accepted start reaches the sequence, the flag or the history.

// File: rtl/bufecc_fixup_pkg.sv
package bufecc_fixup_pkg;

   localparam logic [1:0] FLD_SINGLE = 2'b01;
   localparam logic [1:0] FLD_DOUBLE = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_MAIN,
      ST_WR_MAIN,
      ST_RD_SPARE,
      ST_WR_SPARE,
      ST_FIN
   } fix_state_e;

   typedef struct packed {
      logic fix_main;
      logic fix_spare;
      logic uncorr;
   } fix_plan_t;

endpackage

// File: rtl/bufecc_fixup_decide.sv
module bufecc_fixup_decide
   import bufecc_fixup_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      take_i,
   input  logic [3:0] status_i,
   input  logic      spare_only_i,
   input  logic      hist_mode_i,
   output fix_plan_t plan_o
);

   logic [1:0] main_fld, spare_fld;
   logic       two_bit, main_one, spare_one;
   logic       seen_main_q, seen_spare_q;

   always_comb begin
      main_fld  = status_i[3:2];
      spare_fld = status_i[1:0];
      two_bit   = (main_fld == FLD_DOUBLE) || (spare_fld == FLD_DOUBLE);
      main_one  = (main_fld == FLD_SINGLE);
      spare_one = (spare_fld == FLD_SINGLE);
      plan_o.uncorr    = two_bit;
      plan_o.fix_main  = !two_bit && main_one && !spare_only_i
                         && (!hist_mode_i || seen_main_q);
      plan_o.fix_spare = !two_bit && spare_one
                         && (!hist_mode_i || seen_spare_q);
   end

   // per-region memory of the previous accepted result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_main_q  <= 1'b0;
         seen_spare_q <= 1'b0;
      end else if (take_i) begin
         seen_main_q  <= main_one;
         seen_spare_q <= spare_one;
      end
   end

endmodule

// File: rtl/bufecc_fixup_addr.sv
module bufecc_fixup_addr #(
   parameter  int ADDR_W       = 11,
   parameter  int DATA_W       = 16,
   parameter  int BUF_CNT      = 4,
   parameter  int MAIN_STRIDE  = 256,
   parameter  int SPARE_STRIDE = 8,
   parameter  int MAIN_BASE    = 0,
   parameter  int SPARE_BASE   = 1024,
   localparam int BIT_W        = $clog2(DATA_W),
   localparam int BUF_W        = $clog2(BUF_CNT),
   localparam int MLOC_W       = BIT_W + $clog2(MAIN_STRIDE),
   localparam int SLOC_W       = BIT_W + $clog2(SPARE_STRIDE)
) (
   input  logic [BUF_W-1:0]  buf_sel_i,
   input  logic [MLOC_W-1:0] main_loc_i,
   input  logic [SLOC_W-1:0] spare_loc_i,
   input  logic              sel_spare_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] mask_o
);

   logic [ADDR_W-1:0] main_addr, spare_addr;
   logic [BIT_W-1:0]  bit_pos;

   always_comb begin
      main_addr  = ADDR_W'(MAIN_BASE)
                 + ADDR_W'(main_loc_i[MLOC_W-1:BIT_W])
                 + ADDR_W'(buf_sel_i) * ADDR_W'(MAIN_STRIDE);
      spare_addr = ADDR_W'(SPARE_BASE)
                 + ADDR_W'(spare_loc_i[SLOC_W-1:BIT_W])
                 + ADDR_W'(buf_sel_i) * ADDR_W'(SPARE_STRIDE);
      addr_o     = sel_spare_i ? spare_addr : main_addr;
      bit_pos    = sel_spare_i ? spare_loc_i[BIT_W-1:0] : main_loc_i[BIT_W-1:0];
      mask_o     = DATA_W'(1) << bit_pos;
   end

endmodule

// File: rtl/bufecc_fixup_seq.sv
module bufecc_fixup_seq
   import bufecc_fixup_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  fix_plan_t plan_i,
   output logic      take_o,
   output logic      busy_o,
   output logic      done_o,
   output logic      uncorr_o,
   output logic      rd_o,
   output logic      wr_o,
   output logic      sel_spare_o
);

   fix_state_e state_q;
   fix_plan_t  plan_q;

   assign take_o = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         plan_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               plan_q <= plan_i;
               if (plan_i.fix_main)       state_q <= ST_RD_MAIN;
               else if (plan_i.fix_spare) state_q <= ST_RD_SPARE;
               else                       state_q <= ST_FIN;
            end
            ST_RD_MAIN:  state_q <= ST_WR_MAIN;
            ST_WR_MAIN:  state_q <= plan_q.fix_spare ? ST_RD_SPARE : ST_FIN;
            ST_RD_SPARE: state_q <= ST_WR_SPARE;
            ST_WR_SPARE: state_q <= ST_FIN;
            ST_FIN:      state_q <= ST_IDLE;
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy_o      = (state_q != ST_IDLE);
      done_o      = (state_q == ST_FIN);
      rd_o        = (state_q == ST_RD_MAIN) || (state_q == ST_RD_SPARE);
      wr_o        = (state_q == ST_WR_MAIN) || (state_q == ST_WR_SPARE);
      sel_spare_o = (state_q == ST_RD_SPARE) || (state_q == ST_WR_SPARE);
      uncorr_o    = plan_q.uncorr;
   end

endmodule

// File: rtl/bufecc_fixup.sv
module bufecc_fixup
   import bufecc_fixup_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 16,
   parameter int BUF_CNT      = 4,
   parameter int MAIN_STRIDE  = 256,
   parameter int SPARE_STRIDE = 8,
   parameter int MAIN_BASE    = 0,
   parameter int SPARE_BASE   = 1024
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           start_i,
   input  logic [$clog2(BUF_CNT)-1:0]                     buf_sel_i,
   input  logic                                           spare_only_i,
   input  logic                                           hist_mode_i,
   input  logic [3:0]                                     status_i,
   input  logic [$clog2(DATA_W)+$clog2(MAIN_STRIDE)-1:0]  main_loc_i,
   input  logic [$clog2(DATA_W)+$clog2(SPARE_STRIDE)-1:0] spare_loc_i,
   output logic                                           busy_o,
   output logic                                           done_o,
   output logic                                           uncorr_o,
   output logic                                           ram_rd_o,
   output logic                                           ram_wr_o,
   output logic [ADDR_W-1:0]                              ram_addr_o,
   output logic [DATA_W-1:0]                              ram_wdata_o,
   input  logic [DATA_W-1:0]                              ram_rdata_i
);

   localparam int BIT_W  = $clog2(DATA_W);
   localparam int BUF_W  = $clog2(BUF_CNT);
   localparam int MLOC_W = BIT_W + $clog2(MAIN_STRIDE);
   localparam int SLOC_W = BIT_W + $clog2(SPARE_STRIDE);

   // elaboration-time parameter checks
   if ((1 << BIT_W) != DATA_W) begin : g_chk_data_w
      $error("DATA_W must be a power of two");
   end
   if ((1 << $clog2(MAIN_STRIDE)) != MAIN_STRIDE ||
       (1 << $clog2(SPARE_STRIDE)) != SPARE_STRIDE) begin : g_chk_stride
      $error("region strides must be powers of two");
   end
   if (MAIN_BASE + MAIN_STRIDE * BUF_CNT > SPARE_BASE) begin : g_chk_overlap
      $error("data region overlaps spare region");
   end
   if (SPARE_BASE + SPARE_STRIDE * BUF_CNT > (1 << ADDR_W)) begin : g_chk_fit
      $error("spare region exceeds address space");
   end

   fix_plan_t         plan;
   logic              take, sel_spare;
   logic [BUF_W-1:0]  buf_q;
   logic [MLOC_W-1:0] mloc_q;
   logic [SLOC_W-1:0] sloc_q;
   logic [DATA_W-1:0] flip_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         mloc_q <= '0;
         sloc_q <= '0;
      end else if (take) begin
         buf_q  <= buf_sel_i;
         mloc_q <= main_loc_i;
         sloc_q <= spare_loc_i;
      end
   end

   bufecc_fixup_decide u_decide (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .status_i     (status_i),
      .spare_only_i (spare_only_i),
      .hist_mode_i  (hist_mode_i),
      .plan_o       (plan)
   );

   bufecc_fixup_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .plan_i      (plan),
      .take_o      (take),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .uncorr_o    (uncorr_o),
      .rd_o        (ram_rd_o),
      .wr_o        (ram_wr_o),
      .sel_spare_o (sel_spare)
   );

   bufecc_fixup_addr #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .BUF_CNT      (BUF_CNT),
      .MAIN_STRIDE  (MAIN_STRIDE),
      .SPARE_STRIDE (SPARE_STRIDE),
      .MAIN_BASE    (MAIN_BASE),
      .SPARE_BASE   (SPARE_BASE)
   ) u_addr (
      .buf_sel_i   (buf_q),
      .main_loc_i  (mloc_q),
      .spare_loc_i (sloc_q),
      .sel_spare_i (sel_spare),
      .addr_o      (ram_addr_o),
      .mask_o      (flip_mask)
   );

   assign ram_wdata_o = ram_rdata_i ^ flip_mask;

endmodule

// File: rtl/bufecc_fixup_chk.sv
module bufecc_fixup_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              uncorr_o,
   input logic              ram_rd_o,
   input logic              ram_wr_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [DATA_W-1:0] ram_wdata_o,
   input logic [DATA_W-1:0] ram_rdata_i
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !busy_o && !done_o && !uncorr_o && !ram_rd_o && !ram_wr_o);

   p_single_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_o |-> $countones(ram_wdata_o ^ ram_rdata_i) == 1);

   p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_o |=> ram_wr_o && $stable(ram_addr_o));

   p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_o |-> $past(ram_rd_o));

   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   p_uncorr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr_o && busy_o |-> !ram_rd_o && !ram_wr_o);

   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o && $stable(uncorr_o));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !ram_rd_o && !ram_wr_o && !done_o);

endmodule

bind bufecc_fixup bufecc_fixup_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .uncorr_o    (uncorr_o),
   .ram_rd_o    (ram_rd_o),
   .ram_wr_o    (ram_wr_o),
   .ram_addr_o  (ram_addr_o),
   .ram_wdata_o (ram_wdata_o),
   .ram_rdata_i (ram_rdata_i)
);

// File: tb/bufecc_fixup_tb_top.sv
module bufecc_fixup_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  buf_sel_i = '0;
   logic        spare_only_i = 1'b0;
   logic        hist_mode_i = 1'b0;
   logic [3:0]  status_i = '0;
   logic [11:0] main_loc_i = '0;
   logic [6:0]  spare_loc_i = '0;
   logic        busy_o, done_o, uncorr_o, ram_rd_o, ram_wr_o;
   logic [10:0] ram_addr_o;
   logic [15:0] ram_wdata_o;
   logic [15:0] ram_rdata_i = '0;

   always #2 clk = ~clk;   // 250 MHz

   bufecc_fixup dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .buf_sel_i    (buf_sel_i),
      .spare_only_i (spare_only_i),
      .hist_mode_i  (hist_mode_i),
      .status_i     (status_i),
      .main_loc_i   (main_loc_i),
      .spare_loc_i  (spare_loc_i),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .uncorr_o     (uncorr_o),
      .ram_rd_o     (ram_rd_o),
      .ram_wr_o     (ram_wr_o),
      .ram_addr_o   (ram_addr_o),
      .ram_wdata_o  (ram_wdata_o),
      .ram_rdata_i  (ram_rdata_i)
   );

   // buffer RAM model and the golden image it must end up with
   logic [15:0] mem  [0:2047];
   logic [15:0] gold [0:2047];

   always @(posedge clk) begin
      if (ram_rd_o) ram_rdata_i <= mem[ram_addr_o];
      if (ram_wr_o) mem[ram_addr_o] <= ram_wdata_o;
   end

   int  vectors = 0;
   int  miscompares = 0;
   bit  in_op = 1'b0;
   bit  mon_on = 1'b0;
   bit  finished = 1'b0;
   bit  hist_m = 1'b0;
   bit  hist_s = 1'b0;
   int  q_kind[$];
   int  q_addr[$];
   int  q_data[$];

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // outside operations the RAM port and done must stay quiet
   always @(negedge clk) begin
      if (mon_on && !in_op)
         chk("R5", "idle port", {busy_o, ram_rd_o, ram_wr_o, done_o}, 4'b0000);
   end

   task automatic op(input string tag, input logic [3:0] st, input int idx,
                     input bit sp, input int mloc, input int sloc,
                     input bit hm, input bit poke);
      bit fm, fs, unc, ms, ss;
      int am, as_, n;
      logic [31:0] act, exp;
      @(negedge clk);
      in_op        = 1'b1;
      start_i      = 1'b1;
      status_i     = st;
      buf_sel_i    = 2'(idx);
      spare_only_i = sp;
      hist_mode_i  = hm;
      main_loc_i   = 12'(mloc);
      spare_loc_i  = 7'(sloc);
      // reference decision
      ms  = (st[3:2] == 2'b01);
      ss  = (st[1:0] == 2'b01);
      unc = (st[3:2] == 2'b10) || (st[1:0] == 2'b10);
      fm  = !unc && ms && !sp && (!hm || hist_m);
      fs  = !unc && ss && (!hm || hist_s);
      hist_m = ms;
      hist_s = ss;
      am  = ((mloc >> 4) & 255) + 256 * idx;
      as_ = 1024 + ((sloc >> 4) & 7) + 8 * idx;
      if (fm) begin
         gold[am] = gold[am] ^ 16'(1 << (mloc & 15));
         q_kind.push_back(0); q_addr.push_back(am); q_data.push_back(0);
         q_kind.push_back(1); q_addr.push_back(am); q_data.push_back(int'(gold[am]));
      end
      if (fs) begin
         gold[as_] = gold[as_] ^ 16'(1 << (sloc & 15));
         q_kind.push_back(0); q_addr.push_back(as_); q_data.push_back(0);
         q_kind.push_back(1); q_addr.push_back(as_); q_data.push_back(int'(gold[as_]));
      end
      q_kind.push_back(2); q_addr.push_back(0); q_data.push_back(0);
      @(posedge clk);
      @(negedge clk);
      // R8: disturb every input right after acceptance
      start_i      = 1'b0;
      status_i     = ~st;
      buf_sel_i    = ~buf_sel_i;
      spare_only_i = ~sp;
      hist_mode_i  = ~hm;
      main_loc_i   = ~main_loc_i;
      spare_loc_i  = ~spare_loc_i;
      n = q_kind.size();
      for (int k = 0; k < n; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         act = {1'b0, busy_o, ram_rd_o, ram_wr_o, done_o,
                (ram_rd_o || ram_wr_o) ? ram_addr_o : 11'd0,
                ram_wr_o ? ram_wdata_o : 16'd0};
         exp = {1'b0, 1'b1, q_kind[k] == 0, q_kind[k] == 1, q_kind[k] == 2,
                11'(q_addr[k]), q_kind[k] == 1 ? 16'(q_data[k]) : 16'd0};
         chk(tag, $sformatf("cycle %0d port", k), act, exp);
         if (q_kind[k] == 2) chk(tag, "uncorr at done (R6 R11)", uncorr_o, unc);
         // R9: a start while busy must be ignored
         if (poke) start_i = (k == 0);
      end
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(tag, "back to idle", {busy_o, ram_rd_o, ram_wr_o, done_o}, 4'b0000);
      chk(tag, "uncorr held (R11)", uncorr_o, unc);
      q_kind.delete(); q_addr.delete(); q_data.delete();
      in_op = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      int diffs;
      for (int i = 0; i < 2048; i++) begin
         mem[i]  = 16'(i * 40503 + 7);
         gold[i] = 16'(i * 40503 + 7);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "reset outputs", {busy_o, done_o, uncorr_o, ram_rd_o, ram_wr_o}, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after reset", {busy_o, done_o, uncorr_o, ram_rd_o, ram_wr_o}, 5'b0);
      mon_on = 1'b1;

      op("R3",  4'b0100, 0, 0, 12'h123, 7'h00, 0, 0);
      op("R4",  4'b0001, 2, 0, 12'h000, 7'h35, 0, 0);
      op("R9",  4'b0101, 3, 0, 12'hFFF, 7'h7F, 0, 1);
      op("R6",  4'b1001, 1, 0, 12'h456, 7'h21, 0, 0);
      op("R6",  4'b0110, 2, 0, 12'h456, 7'h21, 0, 1);
      op("R2",  4'b0000, 0, 0, 12'h777, 7'h11, 0, 0);
      op("R2",  4'b1111, 1, 0, 12'h777, 7'h11, 0, 0);
      op("R7",  4'b0101, 1, 1, 12'h2A8, 7'h4C, 0, 0);
      op("R8",  4'b0100, 1, 0, 12'h00A, 7'h00, 0, 1);
      op("R4",  4'b0101, 2, 0, 12'h801, 7'h62, 0, 0);
      // R10: history mode chains
      op("R10", 4'b0000, 0, 0, 12'h010, 7'h10, 1, 0);
      op("R10", 4'b0100, 0, 0, 12'h010, 7'h10, 1, 0);
      op("R10", 4'b0101, 0, 0, 12'h010, 7'h10, 1, 0);
      op("R10", 4'b0001, 0, 0, 12'h010, 7'h13, 1, 0);
      op("R10", 4'b0100, 3, 0, 12'h3C4, 7'h13, 1, 0);
      op("R10", 4'b1001, 3, 0, 12'h3C4, 7'h13, 1, 1);
      op("R10", 4'b0001, 3, 0, 12'h3C4, 7'h56, 1, 0);
      op("R10", 4'b0101, 1, 1, 12'h0F0, 7'h56, 1, 0);

      diffs = 0;
      for (int i = 0; i < 2048; i++)
         if (mem[i] !== gold[i]) diffs++;
      chk("R3", "buffer image mismatches", diffs, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule